// File: doc/BRIEF.md
# Multi-Undo Log Recovery Walker

After a crash, a memory image must be rolled back to the last epoch that was known to be durable. This engine does that rollback. The log holds one record per logged store. Each record carries a line address, a saved pre-image of the line, and two epoch IDs. The "create" ID is the epoch in which the saved image was last produced. The "overwrite" ID is the epoch whose store replaced that image. Recovery software reads the persisted epoch number from its fixed location and passes it in as the target. It then pulses `start`, together with the log's head and tail indices, and waits for `done`.

The engine walks the circular log from the newest record (`log_tail - 1`) back towards the oldest (`log_head`). It fetches one record at a time over a valid/ready read port. A record is restored only when the target epoch falls inside the half-open interval [create, overwrite). A restored record is written to memory over a valid/ready write port, and the engine waits for that acknowledge before it fetches again. Because the walk runs newest first, the oldest qualifying pre-image of a line is written last and wins. The walk ends at the head, or earlier, at the first record whose overwrite ID is below the target. Such a record and every older one can no longer matter.

Top module: `undo_replay_engine`

## Requirements
- R1: A fetched record is written to memory (address and data unchanged) exactly when create <= target and target < overwrite, comparing unsigned 16-bit values.
- R2: A record that fails the interval test, including one with overwrite equal to the target or create above it, produces no memory write, and the walk continues.
- R3: Records are fetched at indices tail-1, tail-2, … in that order. Qualifying records are written in that same newest-first order, so the oldest qualifying image of an address is the last one written.
- R4: When a fetched record has overwrite < target, the walk ends and no further record is fetched.
- R5: The walk ends after the record at `log_head` has been handled. If `log_tail == log_head` at start, no record is fetched at all.
- R6: `done` is high for exactly one cycle. That cycle is the one after the last handshake of the walk: the last write acknowledge, the last read, or the start pulse for an empty log.
- R7: At most one transfer is in flight: `rd_valid` and `wr_valid` are never high together. `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready`.
- R8: `rd_valid` and `rd_idx` hold steady until `rd_ready`.
- R9: After reset, `rd_valid`, `wr_valid` and `done` are low.
- R10: Log indices wrap modulo 2^IDX_W, so a log whose tail index is numerically below its head is walked across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| log_tail | input | IDX_W | One past the newest record |
| log_head | input | IDX_W | Index of the oldest record |
| target_epoch | input | 16 | Persisted epoch to restore to |
| rd_valid | output | 1 | Record fetch request |
| rd_idx | output | IDX_W | Index of the record requested |
| rd_ready | input | 1 | Record fields valid; fetch accepted |
| rd_line_addr | input | LINE_AW | Line address of the record |
| rd_create | input | 16 | Create epoch of the record |
| rd_overwrite | input | 16 | Overwrite epoch of the record |
| rd_line_data | input | LINE_DW | Saved line image |
| wr_valid | output | 1 | Restore write request |
| wr_addr | output | LINE_AW | Line address to restore |
| wr_data | output | LINE_DW | Image to write |
| wr_ready | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle walk-complete pulse |

## Verification
The assertions assume that the record fields are valid in any cycle where `rd_ready` is high together with `rd_valid`. They also assume that epoch IDs do not wrap during a walk and that `start` comes only while the engine is idle. The bench's log responder drives the fields from its model in the same cycle it raises `rd_ready`. The bench pulses `start` only after the previous `done`. All epoch values it uses are small and monotone, so no wrap occurs. Ready signals are stalled in a pseudo-random pattern, which exercises the hold rules.

// File: rtl/undo_replay_pkg.sv
package undo_replay_pkg;
  localparam int EPOCH_W = 16;
  typedef logic [EPOCH_W-1:0] epoch_t;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_WRITE = 2'd2,
    WK_DONE  = 2'd3
  } walk_state_t;

  // Target lies in the half-open interval [create, overwrite).
  function automatic logic interval_hit(epoch_t create, epoch_t overwrite, epoch_t target);
    return (create <= target) && (target < overwrite);
  endfunction

  // Record was overwritten before the target epoch: it and everything older are dead.
  function automatic logic predates_target(epoch_t overwrite, epoch_t target);
    return overwrite < target;
  endfunction
endpackage

// File: rtl/urw_cursor.sv
module urw_cursor #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] tail_in,
  input  logic [IDX_W-1:0] head_in,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             fetch_is_head,
  output logic             cur_at_head,
  output logic             empty_at_load
);
  logic [IDX_W-1:0] cur_q, head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      head_q <= '0;
    end else if (load) begin
      cur_q  <= tail_in;
      head_q <= head_in;
    end else if (step) begin
      cur_q  <= cur_q - 1'b1;
    end
  end

  assign fetch_idx     = cur_q - 1'b1;
  assign fetch_is_head = (fetch_idx == head_q);
  assign cur_at_head   = (cur_q == head_q);
  assign empty_at_load = (tail_in == head_in);

  // R3 / R10: every accepted fetch moves the cursor one slot older, modulo 2^IDX_W
  assert_cursor_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_q == $past(cur_q) - 1'b1));

  // R5: the head stays fixed while walking
  assert_head_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> $stable(head_q));
endmodule

// File: rtl/urw_judge.sv
module urw_judge
  import undo_replay_pkg::*;
(
  input  epoch_t create_id,
  input  epoch_t overwrite_id,
  input  epoch_t target,
  output logic   restore,
  output logic   stale
);
  assign restore = interval_hit(create_id, overwrite_id, target);
  assign stale   = predates_target(overwrite_id, target);
endmodule

// File: rtl/urw_line_hold.sv
module urw_line_hold
  import undo_replay_pkg::*;
#(
  parameter int LINE_AW = 32,
  parameter int LINE_DW = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LINE_AW-1:0] addr_in,
  input  logic [LINE_DW-1:0] data_in,
  input  epoch_t             create_in,
  input  epoch_t             overwrite_in,
  input  epoch_t             target,
  input  logic               pending,
  input  logic               ack,
  output logic [LINE_AW-1:0] addr_out,
  output logic [LINE_DW-1:0] data_out
);
  logic [LINE_AW-1:0] addr_q;
  logic [LINE_DW-1:0] data_q;
  epoch_t             cre_q, ovw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      cre_q  <= '0;
      ovw_q  <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
      cre_q  <= create_in;
      ovw_q  <= overwrite_in;
    end
  end

  assign addr_out = addr_q;
  assign data_out = data_q;

  // R7: an unacknowledged write keeps its address and data
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> (pending && $stable(addr_q) && $stable(data_q)));

  // R1: a pending write always carries a record whose interval holds the target
  assert_wr_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ((cre_q <= target) && (target < ovw_q)));
endmodule

// File: rtl/undo_replay_engine.sv
module undo_replay_engine
  import undo_replay_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int LINE_AW = 32,
  parameter int LINE_DW = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   log_tail,
  input  logic [IDX_W-1:0]   log_head,
  input  logic [15:0]        target_epoch,
  output logic               rd_valid,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic               rd_ready,
  input  logic [LINE_AW-1:0] rd_line_addr,
  input  logic [15:0]        rd_create,
  input  logic [15:0]        rd_overwrite,
  input  logic [LINE_DW-1:0] rd_line_data,
  output logic               wr_valid,
  output logic [LINE_AW-1:0] wr_addr,
  output logic [LINE_DW-1:0] wr_data,
  input  logic               wr_ready,
  output logic               done
);
  walk_state_t state_q, state_d;
  epoch_t      tgt_q;

  // named internal events
  logic launch_w, fetch_fire_w, write_fire_w;
  logic restore_w, stale_w;
  logic fetch_is_head_w, cur_at_head_w, empty_w;
  logic [IDX_W-1:0] fetch_idx_w;

  assign launch_w     = (state_q == WK_IDLE) && start;
  assign fetch_fire_w = (state_q == WK_FETCH) && rd_ready;
  assign write_fire_w = (state_q == WK_WRITE) && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        tgt_q <= '0;
    else if (launch_w) tgt_q <= target_epoch;
  end

  urw_cursor #(.IDX_W(IDX_W)) u_cursor (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (launch_w),
    .step          (fetch_fire_w),
    .tail_in       (log_tail),
    .head_in       (log_head),
    .fetch_idx     (fetch_idx_w),
    .fetch_is_head (fetch_is_head_w),
    .cur_at_head   (cur_at_head_w),
    .empty_at_load (empty_w)
  );

  urw_judge u_judge (
    .create_id    (rd_create),
    .overwrite_id (rd_overwrite),
    .target       (tgt_q),
    .restore      (restore_w),
    .stale        (stale_w)
  );

  urw_line_hold #(.LINE_AW(LINE_AW), .LINE_DW(LINE_DW)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (fetch_fire_w && restore_w),
    .addr_in      (rd_line_addr),
    .data_in      (rd_line_data),
    .create_in    (rd_create),
    .overwrite_in (rd_overwrite),
    .target       (tgt_q),
    .pending      (wr_valid),
    .ack          (wr_ready),
    .addr_out     (wr_addr),
    .data_out     (wr_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:  if (launch_w) state_d = empty_w ? WK_DONE : WK_FETCH;
      WK_FETCH: if (fetch_fire_w) begin
                  if (restore_w)                         state_d = WK_WRITE;
                  else if (stale_w || fetch_is_head_w)   state_d = WK_DONE;
                end
      WK_WRITE: if (write_fire_w) state_d = cur_at_head_w ? WK_DONE : WK_FETCH;
      WK_DONE:  state_d = WK_IDLE;
      default:  state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  assign rd_valid = (state_q == WK_FETCH);
  assign rd_idx   = fetch_idx_w;
  assign wr_valid = (state_q == WK_WRITE);
  assign done     = (state_q == WK_DONE);

  // R7: only one transfer in flight
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R8: a fetch request holds until accepted
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_idx)));

  // R4: a stale record ends the walk with no further fetch
  assert_stop_on_stale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && stale_w) |=> (done && !rd_valid));

  // R2: a record outside its interval never leads to a write
  assert_skip_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !restore_w) |=> !wr_valid);

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1/R4: no record both qualifies and predates the target
  assert_judge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(restore_w && stale_w));
endmodule

// File: tb/undo_replay_engine_bench.sv
module undo_replay_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SLOTS = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] log_tail = '0, log_head = '0;
  logic [15:0] target_epoch = '0;
  logic rd_valid, wr_valid, done;
  logic [IW-1:0] rd_idx;
  logic rd_ready = 1'b0, wr_ready = 1'b0;
  logic [AW-1:0] rd_line_addr = '0, wr_addr;
  logic [15:0] rd_create = '0, rd_overwrite = '0;
  logic [DW-1:0] rd_line_data = '0, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  undo_replay_engine #(.IDX_W(IW), .LINE_AW(AW), .LINE_DW(DW)) u_undo_replay_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .log_tail(log_tail), .log_head(log_head),
    .target_epoch(target_epoch), .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_ready(rd_ready),
    .rd_line_addr(rd_line_addr), .rd_create(rd_create), .rd_overwrite(rd_overwrite),
    .rd_line_data(rd_line_data), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .done(done)
  );

  // log model and memory image
  logic [AW-1:0] m_addr [SLOTS];
  logic [15:0]   m_cre  [SLOTS];
  logic [15:0]   m_ovw  [SLOTS];
  logic [DW-1:0] m_data [SLOTS];
  logic [DW-1:0] mem_img [256];

  logic [AW+DW-1:0] exp_q [$];
  int checks = 0, fails = 0;
  int cyc = 0, last_hs = 0, rd_cnt = 0;
  int exp_reads = 0;
  bit go_req = 0, done_seen = 0, stall_on = 0;
  logic [7:0] lfsr = 8'hA5;
  bit wr_wait = 0;
  logic [AW-1:0] wr_addr_prev;
  logic [DW-1:0] wr_data_prev;

  task automatic note(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor and responders, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    start = 1'b0;
    if (done) begin
      note(cyc == last_hs + 1, "R6", "done timing", cyc, last_hs + 1);
      note(exp_q.size() == 0, "R3", "writes left over", exp_q.size(), 0);
      note(rd_cnt == exp_reads, "R4", "records fetched", rd_cnt, exp_reads);
      done_seen = 1;
    end
    if (wr_wait && wr_valid)
      note(wr_addr == wr_addr_prev && wr_data == wr_data_prev, "R7", "write held",
           wr_addr, wr_addr_prev);
    wr_ready = wr_valid && (!stall_on || lfsr[0]);
    if (wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        note(0, "R2", "unexpected write", wr_addr, 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        note({wr_addr, wr_data} == e, "R1", "write addr/data", {wr_addr, wr_data}, e);
      end
      mem_img[wr_addr[7:0]] = wr_data;
      last_hs = cyc;
    end
    wr_wait = wr_valid && !wr_ready;
    wr_addr_prev = wr_addr;
    wr_data_prev = wr_data;
    rd_ready = rd_valid && (!stall_on || lfsr[1]);
    if (rd_ready) begin
      rd_line_addr = m_addr[rd_idx];
      rd_create    = m_cre[rd_idx];
      rd_overwrite = m_ovw[rd_idx];
      rd_line_data = m_data[rd_idx];
      rd_cnt++;
      last_hs = cyc;
    end
    if (go_req) begin
      start = 1'b1;
      last_hs = cyc;
      go_req = 0;
    end
  end

  // independent restatement of the record rules
  function automatic bit keeps(input logic [15:0] c, input logic [15:0] o, input logic [15:0] t);
    return !(c > t) && (o > t);
  endfunction

  task automatic put(input int i, input logic [AW-1:0] a, input logic [15:0] c,
                     input logic [15:0] o, input logic [DW-1:0] d);
    m_addr[i] = a; m_cre[i] = c; m_ovw[i] = o; m_data[i] = d;
  endtask

  task automatic run_walk(input logic [IW-1:0] head, input logic [IW-1:0] tail,
                          input logic [15:0] t, input bit stalls);
    logic [IW-1:0] p;
    p = tail;
    exp_reads = 0;
    while (p != head) begin
      p = p - 1'b1;
      exp_reads++;
      if (keeps(m_cre[p], m_ovw[p], t)) exp_q.push_back({m_addr[p], m_data[p]});
      else if (m_ovw[p] < t) break;
    end
    @(posedge clk);
    log_head = head; log_tail = tail; target_epoch = t;
    stall_on = stalls; rd_cnt = 0; done_seen = 0;
    go_req = 1;
    wait (done_seen);
    @(posedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem_img[k] = '0;
    for (int k = 0; k < SLOTS; k++) put(k, '0, 16'hFFFF, 16'h0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    note(!rd_valid && !wr_valid && !done, "R9", "outputs in reset",
         {rd_valid, wr_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    note(!rd_valid && !wr_valid && !done, "R9", "idle after reset",
         {rd_valid, wr_valid, done}, 0);

    // R3: two qualifying images of one line, the older one must win
    put(0, 16'h0005, 16'd2, 16'd4, 32'hAAAA0004);
    put(1, 16'h0005, 16'd2, 16'd7, 32'hBBBB0007);
    run_walk(4'd0, 4'd2, 16'd2, 0);
    note(mem_img[5] == 32'hAAAA0004, "R3", "final image", mem_img[5], 32'hAAAA0004);

    // R1/R2: interval boundaries with stalls on both ports
    put(0, 16'h0010, 16'd10, 16'd11, 32'h10101010);
    put(1, 16'h0011, 16'd11, 16'd20, 32'h11111111);
    put(2, 16'h0012, 16'd3,  16'd10, 32'h12121212);
    put(3, 16'h0013, 16'd9,  16'd12, 32'h13131313);
    put(4, 16'h0014, 16'd12, 16'd13, 32'h14141414);
    run_walk(4'd0, 4'd5, 16'd10, 1);
    note(mem_img[8'h11] == 0 && mem_img[8'h12] == 0 && mem_img[8'h14] == 0, "R2",
         "skipped lines untouched", mem_img[8'h12], 0);

    // R4: stale record stops the walk before older qualifying ones
    put(0, 16'h0020, 16'd1, 16'd9,  32'h20202020);
    put(1, 16'h0021, 16'd2, 16'd5,  32'h21212121);
    put(2, 16'h0022, 16'd1, 16'd9,  32'h22222222);
    put(3, 16'h0023, 16'd3, 16'd6,  32'h23232323);
    put(4, 16'h0024, 16'd7, 16'd15, 32'h24242424);
    put(5, 16'h0025, 16'd8, 16'd9,  32'h25252525);
    run_walk(4'd0, 4'd6, 16'd8, 1);
    note(mem_img[8'h20] == 0 && mem_img[8'h22] == 0, "R4", "older lines untouched",
         mem_img[8'h22], 0);

    // R5: empty log
    run_walk(4'd7, 4'd7, 16'd3, 0);

    // R10: walk across the index wrap
    put(14, 16'h0030, 16'd0, 16'd4, 32'h30303030);
    put(15, 16'h0031, 16'd1, 16'd5, 32'h31313131);
    put(0,  16'h0032, 16'd5, 16'd9, 32'h32323232);
    put(1,  16'h0033, 16'd4, 16'd6, 32'h33333333);
    run_walk(4'd14, 4'd2, 16'd4, 1);
    note(mem_img[8'h31] == 32'h31313131 && mem_img[8'h30] == 0, "R10", "wrapped walk image",
         mem_img[8'h31], 32'h31313131);

    // R5: single-record log whose record is the head and qualifies
    put(9, 16'h0040, 16'd3, 16'd4, 32'h40404040);
    run_walk(4'd9, 4'd10, 16'd3, 1);
    note(mem_img[8'h40] == 32'h40404040, "R5", "head record restored", mem_img[8'h40], 32'h40404040);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule